// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block collects the four interrupt conditions of a UART and turns them into one interrupt request and one readable identification byte. The four conditions are receiver line status errors, received data available or a receive character timeout, an empty transmit holding register, and a change on the modem status inputs. The serial datapath, the baud generator and the FIFOs lie outside the block. They report to it through single-cycle event pulses and level inputs.

The host controls four per-source enable bits. It reads the identification byte to learn which enabled source has the highest priority. The block also applies the clearing side effects of host accesses: reading line status, reading modem status, writing the holding register, and reading the identification byte while it shows the holding-empty source. Two of the conditions are treated as levels and are owned by the datapath: received data available and character timeout. Line status, holding-empty and modem change are latched inside the block until their clearing access arrives.

Top module: `uirq_ident`

## Requirements
- R1: When several enabled sources are pending, the identification byte reports line status first, then received data or timeout, then holding-register empty, and modem status last.
- R2: Identification bit 0 reads 0 when any enabled source is pending. It reads 1 when none is pending, and bits 3:0 are then 0001.
- R3: The identification codes in bits 3:0 are as follows: line status 0110, received data 0100, holding-register empty 0010, modem status 0000.
- R4: Character timeout reports code 1100 and takes precedence over plain data available. The timeout input is ignored while FIFO mode is off, so bit 3 stays 0 in that mode.
- R5: Identification bits 5:4 always read 0.
- R6: Identification bits 7:6 both equal the FIFO-enable input.
- R7: The enable register is written through ierWe and ierWdata. Its bit 0 enables received data and timeout, bit 1 holding-register empty, bit 2 line status and bit 3 modem status. A disabled source is reported nowhere. A latched condition stays latched while it is disabled and appears once its enable bit is set.
- R8: A line-status read clears the latched line-status condition.
- R9: A holding-register write clears the holding-empty condition. An identification read also clears it, but only when the byte currently reads code 0010.
- R10: A modem-status read clears the latched modem condition.
- R11: irq is a register. It equals, one clock later, whether any enabled source was pending; after reset it is 0.
- R12: A new event in the same cycle as its clearing access leaves the condition pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ierWe | input | 1 | Write strobe for the enable register |
| ierWdata | input | 4 | Enable register write data |
| fifoEnable | input | 1 | FIFO mode on (FIFO control bit 0) |
| iirRead | input | 1 | Host reads the identification byte |
| lsrRead | input | 1 | Host reads the line status register |
| msrRead | input | 1 | Host reads the modem status register |
| thrWrite | input | 1 | Host writes the transmit holding register |
| lineErrEvt | input | 1 | Pulse: receive line error detected |
| rxAvail | input | 1 | Level: received data available |
| rxTimeout | input | 1 | Level: receive character timeout |
| thrEmptyEvt | input | 1 | Pulse: holding register became empty |
| modemChgEvt | input | 1 | Pulse: modem status input changed |
| irq | output | 1 | Registered interrupt request |
| iidByte | output | 8 | Interrupt identification byte |

## Verification
The bench builds the block with its default parameters: an 8-bit identification byte, a 4-bit enable register and three latched sources. These are the only widths the code layout allows. With them, every code value, every pairing of sources that tests priority, and both FIFO modes can be reached by directed stimulus. Each scenario is applied with the other sources idle or deliberately competing. This shows that the clearing accesses hit only their own source: for example, an identification read while a higher source hides the holding-empty code must leave that condition pending.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int ID_W  = 8;
  localparam int EN_W  = 4;
  localparam int NUM_LAT = 3;

  // latched source slots
  localparam int LAT_LINE  = 0;
  localparam int LAT_THRE  = 1;
  localparam int LAT_MODEM = 2;

  // enable register bit positions
  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  localparam logic [3:0] CODE_LINE  = 4'b0110;
  localparam logic [3:0] CODE_RX    = 4'b0100;
  localparam logic [3:0] CODE_TMO   = 4'b1100;
  localparam logic [3:0] CODE_THRE  = 4'b0010;
  localparam logic [3:0] CODE_MODEM = 4'b0000;
  localparam logic [3:0] CODE_NONE  = 4'b0001;

  typedef struct packed {
    logic [NUM_LAT-1:0] set;
    logic [NUM_LAT-1:0] clr;
  } latchStrobes_t;
endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic          iirRead,
  input  logic          lsrRead,
  input  logic          msrRead,
  input  logic          thrWrite,
  input  logic          lineErrEvt,
  input  logic          thrEmptyEvt,
  input  logic          modemChgEvt,
  input  logic          threShown,
  output latchStrobes_t stb
);
  always_comb begin
    stb = '0;
    stb.set[LAT_LINE]  = lineErrEvt;
    stb.set[LAT_THRE]  = thrEmptyEvt;
    stb.set[LAT_MODEM] = modemChgEvt;
    stb.clr[LAT_LINE]  = lsrRead;
    // an identification read only consumes holding-empty when it is the code shown
    stb.clr[LAT_THRE]  = thrWrite | (iirRead & threShown);
    stb.clr[LAT_MODEM] = msrRead;
  end
endmodule

// File: rtl/uirq_datapath.sv
module uirq_datapath
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  latchStrobes_t   stb,
  input  logic            ierWe,
  input  logic [EN_W-1:0] ierWdata,
  input  logic            fifoEnable,
  input  logic            rxAvail,
  input  logic            rxTimeout,
  output logic [ID_W-1:0] iidByte,
  output logic            irq,
  output logic            threShown
);
  logic [NUM_LAT-1:0] pend;
  logic [EN_W-1:0]    ier;
  logic lineAct, rxAct, tmoAct, threAct, modemAct, anyAct;
  logic [3:0] code;

  // one sticky flag per latched source; a set in the same cycle beats a clear
  for (genvar i = 0; i < NUM_LAT; i++) begin : gLatch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             pend[i] <= 1'b0;
      else if (stb.set[i])   pend[i] <= 1'b1;
      else if (stb.clr[i])   pend[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ier <= '0;
    else if (ierWe) ier <= ierWdata;
  end

  always_comb begin
    lineAct  = pend[LAT_LINE]  & ier[EN_LINE];
    tmoAct   = rxTimeout & fifoEnable & ier[EN_RX];
    rxAct    = (rxAvail & ier[EN_RX]) | tmoAct;
    threAct  = pend[LAT_THRE]  & ier[EN_THRE];
    modemAct = pend[LAT_MODEM] & ier[EN_MODEM];
    anyAct   = lineAct | rxAct | threAct | modemAct;
    if (lineAct)       code = CODE_LINE;
    else if (tmoAct)   code = CODE_TMO;
    else if (rxAct)    code = CODE_RX;
    else if (threAct)  code = CODE_THRE;
    else if (modemAct) code = CODE_MODEM;
    else               code = CODE_NONE;
    threShown = (code == CODE_THRE);
    iidByte   = {{(ID_W-6){fifoEnable}}, 2'b00, code};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= anyAct;
  end

  AST_IRQ_FOLLOWS_ID: assert property (@(posedge clk) disable iff (!rstN)
    irq == !$past(iidByte[0])); // R11
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    iidByte[5:4] == 2'b00); // R5
  AST_NONFIFO_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEnable |-> (iidByte[7:6] == 2'b00 && !iidByte[3])); // R4
  AST_LINE_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.set[LAT_LINE] && ier[EN_LINE] && !ierWe) |=> iidByte[3:0] == CODE_LINE); // R12
  AST_IER_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ierWe && ierWdata == '0) |=> iidByte[0]); // R7
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            ierWe,
  input  logic [EN_W-1:0] ierWdata,
  input  logic            fifoEnable,
  input  logic            iirRead,
  input  logic            lsrRead,
  input  logic            msrRead,
  input  logic            thrWrite,
  input  logic            lineErrEvt,
  input  logic            rxAvail,
  input  logic            rxTimeout,
  input  logic            thrEmptyEvt,
  input  logic            modemChgEvt,
  output logic            irq,
  output logic [ID_W-1:0] iidByte
);
  latchStrobes_t stb;
  logic threShown;

  uirq_ctrl uCtrl (
    .iirRead(iirRead), .lsrRead(lsrRead), .msrRead(msrRead), .thrWrite(thrWrite),
    .lineErrEvt(lineErrEvt), .thrEmptyEvt(thrEmptyEvt), .modemChgEvt(modemChgEvt),
    .threShown(threShown), .stb(stb)
  );

  uirq_datapath uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .ierWe(ierWe), .ierWdata(ierWdata),
    .fifoEnable(fifoEnable), .rxAvail(rxAvail), .rxTimeout(rxTimeout),
    .iidByte(iidByte), .irq(irq), .threShown(threShown)
  );

  AST_LSR_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !lineErrEvt) |=> iidByte[3:0] != CODE_LINE); // R8
  AST_THR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (thrWrite && !thrEmptyEvt && !ierWe) |=> iidByte[3:0] != CODE_THRE); // R9
  AST_MSR_CLEARS_MODEM: assert property (@(posedge clk) disable iff (!rstN)
    (msrRead && !modemChgEvt && !ierWe) |=> iidByte[3:0] != CODE_MODEM); // R10
endmodule

// File: tb/tb_uirq_ident.sv
module tb_uirq_ident;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ierWe = 0, fifoEnable = 0, iirRead = 0, lsrRead = 0, msrRead = 0, thrWrite = 0;
  logic [3:0] ierWdata = '0;
  logic lineErrEvt = 0, rxAvail = 0, rxTimeout = 0, thrEmptyEvt = 0, modemChgEvt = 0;
  logic irq;
  logic [7:0] iidByte;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uirq_ident dut (
    .clk(clk), .rstN(rstN), .ierWe(ierWe), .ierWdata(ierWdata), .fifoEnable(fifoEnable),
    .iirRead(iirRead), .lsrRead(lsrRead), .msrRead(msrRead), .thrWrite(thrWrite),
    .lineErrEvt(lineErrEvt), .rxAvail(rxAvail), .rxTimeout(rxTimeout),
    .thrEmptyEvt(thrEmptyEvt), .modemChgEvt(modemChgEvt), .irq(irq), .iidByte(iidByte)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chkId(input logic [7:0] exp, input string req);
    checks++;
    if (iidByte !== exp) begin
      failures++;
      $display("FAIL %s iidByte actual=%02h expected=%02h", req, iidByte, exp);
    end
  endtask

  task automatic chkIrq(input logic exp, input string req);
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, irq, exp);
    end
  endtask

  task automatic setIer(input logic [3:0] v);
    ierWe = 1; ierWdata = v; step(); ierWe = 0;
  endtask

  task automatic testReset();
    chkId(8'h01, "R2 reset");
    chkIrq(1'b0, "R11 reset");
  endtask

  task automatic testThreModem();
    setIer(4'hF);
    thrEmptyEvt = 1; step(); thrEmptyEvt = 0;
    chkId(8'h02, "R3 thre code");
    chkIrq(1'b0, "R11 irq one cycle late");
    step();
    chkIrq(1'b1, "R11 irq raised");
    modemChgEvt = 1; step(); modemChgEvt = 0;
    chkId(8'h02, "R1 thre over modem");
    iirRead = 1; step(); iirRead = 0;
    chkId(8'h00, "R9 iir read clears thre, R3 modem code");
    msrRead = 1; step(); msrRead = 0;
    chkId(8'h01, "R10 msr read clears modem");
    step();
    chkIrq(1'b0, "R11 irq dropped");
  endtask

  task automatic testRxLine();
    rxAvail = 1; step();
    chkId(8'h04, "R3 rx data code");
    lineErrEvt = 1; step(); lineErrEvt = 0;
    chkId(8'h06, "R1 line over rx");
    lsrRead = 1; step(); lsrRead = 0;
    chkId(8'h04, "R8 lsr read clears line");
    rxAvail = 0; step();
    chkId(8'h01, "R2 none after rx drop");
  endtask

  task automatic testTimeout();
    rxTimeout = 1; step();
    chkId(8'h01, "R4 timeout ignored without fifo");
    fifoEnable = 1; step();
    chkId(8'hCC, "R4 timeout code in fifo mode, R6 R5");
    rxAvail = 1; step();
    chkId(8'hCC, "R4 timeout precedes data");
    rxTimeout = 0; step();
    chkId(8'hC4, "R6 fifo bits with data");
    rxAvail = 0; step();
    chkId(8'hC1, "R6 fifo bits when idle");
    fifoEnable = 0; step();
    chkId(8'h01, "R6 fifo bits cleared");
  endtask

  task automatic testGating();
    setIer(4'h0);
    lineErrEvt = 1; step(); lineErrEvt = 0;
    chkId(8'h01, "R7 disabled line hidden");
    step();
    chkIrq(1'b0, "R7 disabled no irq");
    setIer(4'b0100);
    chkId(8'h06, "R7 latched line appears on enable");
    thrEmptyEvt = 1; step(); thrEmptyEvt = 0;
    chkId(8'h06, "R7 thre disabled hidden");
    setIer(4'hF);
    iirRead = 1; step(); iirRead = 0;
    lsrRead = 1; step(); lsrRead = 0;
    chkId(8'h02, "R9 iir read under line keeps thre");
    thrWrite = 1; step(); thrWrite = 0;
    chkId(8'h01, "R9 thr write clears thre");
  endtask

  task automatic testSetWins();
    lineErrEvt = 1; lsrRead = 1; step(); lineErrEvt = 0; lsrRead = 0;
    chkId(8'h06, "R12 line event beats lsr read");
    thrEmptyEvt = 1; thrWrite = 1; step(); thrEmptyEvt = 0; thrWrite = 0;
    lsrRead = 1; step(); lsrRead = 0;
    chkId(8'h02, "R12 thre event beats thr write");
    thrWrite = 1; step(); thrWrite = 0;
    modemChgEvt = 1; msrRead = 1; step(); modemChgEvt = 0; msrRead = 0;
    chkId(8'h00, "R12 modem event beats msr read");
    msrRead = 1; step(); msrRead = 0;
    chkId(8'h01, "R10 modem cleared");
  endtask

  initial begin
    step(); step();
    testReset();
    rstN = 1;
    step();
    testReset();
    testThreModem();
    testRxLine();
    testTimeout();
    testGating();
    testSetWins();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule